// File: doc/BRIEF.md
# Interrupt Priority Status Register Controller

This block keeps the processor's 8-bit status word and decides whether a pending maskable interrupt may be taken. The word holds an interrupt enable flag, a two-bit in-service priority field, the zero, carry and auxiliary-carry flags, and two register-bank select bits. The arithmetic flags and bank bits are plain storage here. Software changes them through the byte write port, the single-bit set and clear port, or the restore port.

On acknowledge, the control sequencer reads the current word from `word_o` and stores it to the stack. It then pulses `ack_vec` (or `brk` for a software break). On that edge the enable flag is cleared. If a maskable request was pending, the in-service field takes that request's level, so only requests of equal or more urgent level can nest once interrupts are re-enabled. A return or pop instruction drives the saved byte on `ret_data` with `ret_en`, and the whole word is reloaded.

Top module: `irq_status_word`

## Requirements
- R1: While `rst_n` is low the word is 8'h06: enable flag 0, in-service priority 2'b11, every other bit 0.
- R2: The word's bit positions are 7 enable flag, 6 zero, 5 bank-select high, 4 auxiliary carry, 3 bank-select low, 2:1 in-service priority (bit 2 most significant), 0 carry. The flag outputs mirror those bits.
- R3: On a clock edge with `ack_vec` or `brk` high, the enable flag becomes 0. `word_o` shows the pre-edge word during that cycle for saving. A break, or an acknowledge without `irq_pend`, leaves every other bit unchanged.
- R4: On a clock edge with `ack_vec` and `irq_pend` both high, bits 2:1 take `irq_lvl`.
- R5: `irq_accept` is combinational and is 1 exactly when `irq_pend` is 1, the enable flag is 1 and `irq_lvl` is numerically at most the in-service priority. Level 0 is the most urgent. It does not depend on `ack_vec`.
- R6: `ret_en` loads the whole word from `ret_data` on the next edge.
- R7: `wr_en` loads the whole word from `wr_data` on the next edge.
- R8: `bit_set` or `bit_clr` sets or clears the bit indexed by `bit_sel`. When both are high, the bit is set.
- R9: `ie_set` sets and `ie_clr` clears the enable flag. When both are high, the flag is cleared.
- R10: When several operations fall in one cycle, only the highest takes effect. The order from highest is acknowledge or break, restore, byte write, bit set or clear, enable or disable.
- R11: In a cycle with no strobe the word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| irq_pend | input | 1 | A maskable request is pending |
| irq_lvl | input | 2 | Priority level of the pending request, 0 most urgent |
| ack_vec | input | 1 | Vectored acknowledge strobe |
| brk | input | 1 | Software break strobe |
| ie_set | input | 1 | Enable maskable interrupts |
| ie_clr | input | 1 | Disable maskable interrupts |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write data |
| bit_set | input | 1 | Single-bit set strobe |
| bit_clr | input | 1 | Single-bit clear strobe |
| bit_sel | input | 3 | Bit index for set or clear |
| ret_en | input | 1 | Restore strobe (return or pop) |
| ret_data | input | 8 | Byte restored from the stack |
| word_o | output | 8 | Current word, for reading, pushing and saving |
| irq_accept | output | 1 | Pending request may be taken |
| ie_o | output | 1 | Enable flag |
| isp_o | output | 2 | In-service priority |
| rbs_o | output | 2 | Register-bank select |
| zf_o | output | 1 | Zero flag |
| acf_o | output | 1 | Auxiliary carry flag |
| cf_o | output | 1 | Carry flag |

## Verification
The most delicate collision is an acknowledge or break landing in the same cycle as a restore. This is the case of a return instruction being overtaken by a new interrupt. Here the acknowledge must win, and the saved byte must be the pre-edge word. The bench provokes it by raising `brk` together with `ret_en`, and later `ack_vec` together with `ret_en`, with restore data that differs from the expected result. It then judges the outcome from `word_o` on the following cycle. Restore against write, bit set against bit clear, bit operation against enable, and enable against disable are forced the same way, and each uses data that would betray the losing operation.

// File: rtl/isw_pkg.sv
package isw_pkg;
  localparam int WORD_W = 8;
  localparam int LVL_W  = 2;
  localparam int SEL_W  = $clog2(WORD_W);

  localparam int B_IE   = 7;
  localparam int B_Z    = 6;
  localparam int B_RBSH = 5;
  localparam int B_AC   = 4;
  localparam int B_RBSL = 3;
  localparam int B_ISPH = 2;
  localparam int B_ISPL = 1;
  localparam int B_CY   = 0;

  localparam logic [WORD_W-1:0] RST_WORD = 8'h06;

  typedef struct packed {
    logic ack;
    logic brk;
    logic ret;
    logic wr;
    logic bset;
    logic bclr;
    logic eset;
    logic eclr;
  } strobe_t;
endpackage

// File: rtl/isw_admit.sv
module isw_admit
  import isw_pkg::*;
(
  input  logic             pend,
  input  logic [LVL_W-1:0] lvl,
  input  logic             ie,
  input  logic [LVL_W-1:0] isp,
  output logic             accept
);
  logic lvl_ok;

  always_comb begin
    lvl_ok = (lvl <= isp);
    accept = pend & ie & lvl_ok;
  end
endmodule

// File: rtl/isw_next.sv
module isw_next
  import isw_pkg::*;
(
  input  logic [WORD_W-1:0] cur,
  input  strobe_t           stb,
  input  logic              pend,
  input  logic [LVL_W-1:0]  lvl,
  input  logic [WORD_W-1:0] ret_data,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  bit_sel,
  output logic [WORD_W-1:0] nxt,
  output logic              load_en
);
  logic [WORD_W-1:0] sel_mask;
  logic [WORD_W-1:0] bit_word;
  logic [WORD_W-1:0] ack_word;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign sel_mask[i] = (bit_sel == SEL_W'(i));
    assign bit_word[i] = sel_mask[i] ? stb.bset : cur[i];
  end

  always_comb begin
    ack_word       = cur;
    ack_word[B_IE] = 1'b0;
    if (stb.ack && pend) begin
      ack_word[B_ISPH:B_ISPL] = lvl;
    end
  end

  always_comb begin
    nxt = cur;
    if (stb.ack || stb.brk) begin
      nxt = ack_word;
    end else if (stb.ret) begin
      nxt = ret_data;
    end else if (stb.wr) begin
      nxt = wr_data;
    end else if (stb.bset || stb.bclr) begin
      nxt = bit_word;
    end else if (stb.eset || stb.eclr) begin
      nxt[B_IE] = ~stb.eclr;
    end
    load_en = |stb;
  end
endmodule

// File: rtl/irq_status_word.sv
module irq_status_word
  import isw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_pend,
  input  logic [1:0]       irq_lvl,
  input  logic             ack_vec,
  input  logic             brk,
  input  logic             ie_set,
  input  logic             ie_clr,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             bit_set,
  input  logic             bit_clr,
  input  logic [2:0]       bit_sel,
  input  logic             ret_en,
  input  logic [7:0]       ret_data,
  output logic [7:0]       word_o,
  output logic             irq_accept,
  output logic             ie_o,
  output logic [1:0]       isp_o,
  output logic [1:0]       rbs_o,
  output logic             zf_o,
  output logic             acf_o,
  output logic             cf_o
);
  strobe_t           stb;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;
  logic              word_en;

  always_comb begin
    stb.ack  = ack_vec;
    stb.brk  = brk;
    stb.ret  = ret_en;
    stb.wr   = wr_en;
    stb.bset = bit_set;
    stb.bclr = bit_clr;
    stb.eset = ie_set;
    stb.eclr = ie_clr;
  end

  isw_next u_next (
    .cur      (word_q),
    .stb      (stb),
    .pend     (irq_pend),
    .lvl      (irq_lvl),
    .ret_data (ret_data),
    .wr_data  (wr_data),
    .bit_sel  (bit_sel),
    .nxt      (word_d),
    .load_en  (word_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= RST_WORD;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  isw_admit u_admit (
    .pend   (irq_pend),
    .lvl    (irq_lvl),
    .ie     (word_q[B_IE]),
    .isp    (word_q[B_ISPH:B_ISPL]),
    .accept (irq_accept)
  );

  always_comb begin
    word_o = word_q;
    ie_o   = word_q[B_IE];
    isp_o  = word_q[B_ISPH:B_ISPL];
    rbs_o  = {word_q[B_RBSH], word_q[B_RBSL]};
    zf_o   = word_q[B_Z];
    acf_o  = word_q[B_AC];
    cf_o   = word_q[B_CY];
  end
endmodule

// File: rtl/isw_checker.sv
module isw_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_pend,
  input logic [1:0] irq_lvl,
  input logic       ack_vec,
  input logic       brk,
  input logic       ie_set,
  input logic       ie_clr,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       bit_set,
  input logic       bit_clr,
  input logic       ret_en,
  input logic [7:0] ret_data,
  input logic [7:0] word_o,
  input logic       irq_accept,
  input logic       ie_o,
  input logic [1:0] isp_o
);
  logic any_stb;
  assign any_stb = ack_vec | brk | ret_en | wr_en | bit_set | bit_clr | ie_set | ie_clr;

  p_ack_clears_ie_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vec || brk) |=> !ie_o);

  p_ack_loads_isp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vec && irq_pend) |=> (isp_o == $past(irq_lvl)));

  p_no_accept_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_o |-> !irq_accept);

  p_accept_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_o && irq_pend && isp_o == 2'b11) |-> irq_accept);

  p_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && !ack_vec && !brk) |=> (word_o == $past(ret_data)));

  p_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ret_en && !ack_vec && !brk) |=> (word_o == $past(wr_data)));

  p_ie_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_set && !ie_clr && !ack_vec && !brk && !ret_en && !wr_en && !bit_set && !bit_clr)
    |=> ie_o);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !any_stb |=> $stable(word_o));
endmodule

bind irq_status_word isw_checker u_isw_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_pend   (irq_pend),
  .irq_lvl    (irq_lvl),
  .ack_vec    (ack_vec),
  .brk        (brk),
  .ie_set     (ie_set),
  .ie_clr     (ie_clr),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .bit_set    (bit_set),
  .bit_clr    (bit_clr),
  .ret_en     (ret_en),
  .ret_data   (ret_data),
  .word_o     (word_o),
  .irq_accept (irq_accept),
  .ie_o       (ie_o),
  .isp_o      (isp_o)
);

// File: tb/irq_status_word_test.sv
module irq_status_word_test;
  logic       clk;
  logic       rst_n;
  logic       irq_pend;
  logic [1:0] irq_lvl;
  logic       ack_vec, brk, ie_set, ie_clr, wr_en, bit_set, bit_clr, ret_en;
  logic [7:0] wr_data, ret_data;
  logic [2:0] bit_sel;
  logic [7:0] word_o;
  logic       irq_accept, ie_o, zf_o, acf_o, cf_o;
  logic [1:0] isp_o, rbs_o;

  int tests = 0;
  int fails = 0;

  // strobe mask: ack, brk, ret, wr, bset, bclr, eset, eclr
  localparam logic [7:0] S_ACK = 8'h80, S_BRK = 8'h40, S_RET = 8'h20, S_WR = 8'h10;
  localparam logic [7:0] S_BS  = 8'h08, S_BC  = 8'h04, S_ES  = 8'h02, S_EC = 8'h01;

  typedef struct packed {
    logic       pend;
    logic [1:0] lvl;
    logic [7:0] stb;
    logic [7:0] d;     // ret_data = d, wr_data = ~d
    logic [2:0] sel;
    logic       acc;
    logic [7:0] word;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, S_ES,          8'h00, 3'd0, 1'b0, 8'h86}, // R9 enable
    '{1'b1, 2'd3, 8'h00,         8'h00, 3'd0, 1'b1, 8'h86}, // R5 open level
    '{1'b1, 2'd2, S_ACK,         8'h00, 3'd0, 1'b1, 8'h04}, // R3 R4 ack loads level
    '{1'b1, 2'd3, S_ES,          8'h00, 3'd0, 1'b0, 8'h84}, // R5 disabled
    '{1'b1, 2'd3, 8'h00,         8'h00, 3'd0, 1'b0, 8'h84}, // R5 level above isp
    '{1'b1, 2'd2, 8'h00,         8'h00, 3'd0, 1'b1, 8'h84}, // R5 level equal isp
    '{1'b0, 2'd0, S_WR,          8'h00, 3'd0, 1'b0, 8'hFF}, // R7 write
    '{1'b0, 2'd0, S_BC,          8'h00, 3'd6, 1'b0, 8'hBF}, // R8 clear bit 6
    '{1'b0, 2'd0, S_BS | S_BC,   8'h00, 3'd6, 1'b0, 8'hFF}, // R8 set wins
    '{1'b0, 2'd0, S_ES | S_EC,   8'h00, 3'd0, 1'b0, 8'h7F}, // R9 clear wins
    '{1'b0, 2'd0, S_RET | S_WR,  8'h5A, 3'd0, 1'b0, 8'h5A}, // R6 R10 restore over write
    '{1'b0, 2'd0, S_ES,          8'h00, 3'd0, 1'b0, 8'hDA}, // R9
    '{1'b1, 2'd0, S_BRK | S_RET, 8'h00, 3'd0, 1'b1, 8'h5A}, // R3 R10 break over restore
    '{1'b1, 2'd0, S_ACK,         8'h00, 3'd0, 1'b0, 8'h58}, // R4 level 0
    '{1'b0, 2'd0, S_WR,          8'h7E, 3'd0, 1'b0, 8'h81}, // R7
    '{1'b1, 2'd0, 8'h00,         8'h00, 3'd0, 1'b1, 8'h81}, // R5 isp 0 admits 0
    '{1'b1, 2'd1, 8'h00,         8'h00, 3'd0, 1'b0, 8'h81}, // R5 isp 0 blocks 1
    '{1'b0, 2'd0, S_ACK | S_RET, 8'hFF, 3'd0, 1'b0, 8'h01}, // R3 R10 ack w/o pend
    '{1'b0, 2'd0, S_WR | S_BC,   8'hBF, 3'd6, 1'b0, 8'h40}, // R10 write over bit op
    '{1'b0, 2'd0, S_BS | S_EC,   8'h00, 3'd7, 1'b0, 8'hC0}, // R10 bit op over enable
    '{1'b0, 2'd0, 8'h00,         8'h00, 3'd0, 1'b0, 8'hC0}  // R11 hold
  };

  irq_status_word uut (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_lvl(irq_lvl),
    .ack_vec(ack_vec), .brk(brk), .ie_set(ie_set), .ie_clr(ie_clr),
    .wr_en(wr_en), .wr_data(wr_data), .bit_set(bit_set), .bit_clr(bit_clr),
    .bit_sel(bit_sel), .ret_en(ret_en), .ret_data(ret_data), .word_o(word_o),
    .irq_accept(irq_accept), .ie_o(ie_o), .isp_o(isp_o), .rbs_o(rbs_o),
    .zf_o(zf_o), .acf_o(acf_o), .cf_o(cf_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic drive(input logic p, input logic [1:0] l, input logic [7:0] s,
                       input logic [7:0] d, input logic [2:0] sel);
    irq_pend = p; irq_lvl = l;
    {ack_vec, brk, ret_en, wr_en, bit_set, bit_clr, ie_set, ie_clr} = s;
    ret_data = d; wr_data = ~d; bit_sel = sel;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b1, 2'd0, 8'h00, 8'h00, 3'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset word", word_o, 8'h06);
    check("R2 isp field", {6'd0, isp_o}, 8'h03);
    check("R5 no accept while disabled", {7'd0, irq_accept}, 8'h00);
    rst_n = 1'b1;
    drive(1'b0, 2'd0, 8'h00, 8'h00, 3'd0);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].pend, VECS[i].lvl, VECS[i].stb, VECS[i].d, VECS[i].sel);
      #1;
      check($sformatf("R5 accept vec %0d", i), {7'd0, irq_accept}, {7'd0, VECS[i].acc});
      @(posedge clk);
      #1;
      drive(1'b0, 2'd0, 8'h00, 8'h00, 3'd0);
      check($sformatf("R3/R10 word vec %0d", i), word_o, VECS[i].word);
    end

    // R2 flag outputs from a known word: 8'b0110_1101
    @(negedge clk);
    drive(1'b0, 2'd0, S_WR, 8'h92, 3'd0);
    @(posedge clk); #1;
    drive(1'b0, 2'd0, 8'h00, 8'h00, 3'd0);
    check("R2 flags", {ie_o, zf_o, rbs_o[1], acf_o, rbs_o[0], isp_o, cf_o}, 8'h6D);

    // R3 save value visible before the acknowledge edge
    @(negedge clk);
    drive(1'b1, 2'd1, S_ACK, 8'h00, 3'd0);
    #1;
    check("R3 save word before edge", word_o, 8'h6D);
    @(posedge clk); #1;
    drive(1'b0, 2'd0, 8'h00, 8'h00, 3'd0);
    check("R4 ack level 1", word_o, 8'h6B);

    // R1 asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", word_o, 8'h06);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 hold after reset", word_o, 8'h06);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule